// File: doc/BRIEF.md
# Serial Frame Sync Generator

This block makes the timing for a serial audio port: a bit clock and a periodic frame sync pulse. The bit clock is either divided down from the system clock or taken from an external bit-clock pin through a synchronizer. Frame sync timing is always generated internally. The frame sync logic counts rising bit-clock edges. Its frame period and its pulse width are set by two fields, each written as the wanted count minus one. For 16-bit stereo a user sets the period field to 31 and the width field to 15. This gives a 32-clock frame with the pulse held for the first 16 clocks.

The generator and the frame sync logic each have their own active-low hold control, so one can run while the other is held. In free-running mode a pulse comes out every frame. Otherwise one frame is emitted for each trigger request. A polarity bit picks an active-high or active-low frame sync. Every configuration field is captured at a frame boundary, so a frame that is already running keeps its length and width. Everything runs in the system clock domain. A one-cycle frame-start strobe marks the first bit clock of each frame. Data shifting lies outside this block.

Top module: `frame_sync_gen`

## Requirements
- R1: Each frame lasts `cfg_period`+1 bit clocks. From one `frame_start` strobe to the next is (`cfg_period`+1)·2·(`cfg_div`+1) system clocks in internal mode.
- R2: The frame sync is active for the first `cfg_width`+1 bit clocks of a frame. If `cfg_width` ≥ `cfg_period`, it is active for the whole frame.
- R3: With `clk_sel`=0 the bit clock is the system clock divided by 2·(`cfg_div`+1), with a 50 % duty cycle: high for `cfg_div`+1 cycles, then low for `cfg_div`+1 cycles.
- R4: With `cfg_free_run`=1, frames follow each other back to back with no trigger needed.
- R5: With `cfg_free_run`=0, no frame starts until `frame_trig` is seen high on a clock edge. One trigger yields exactly one frame.
- R6: While `gen_rst_n`=0 the bit clock stays low and no frame starts.
- R7: While `fsync_rst_n`=0 the frame sync sits at its inactive level and `frame_start` stays low, even when the bit clock runs.
- R8: `cfg_fs_low`=1 makes the frame sync active low (inactive level 1). `cfg_fs_low`=0 makes it active high (inactive level 0).
- R9: With `clk_sel`=1 the bit clock is `ext_bclk` after a two-stage synchronizer, and frames are counted in its periods.
- R10: `frame_start` is high for exactly one system clock, in the cycle where the frame sync first turns active for a frame.
- R11: A change to the period or width fields during a frame does not alter that frame. It applies from the next frame.
- R12: After `rst_n`=0: `bclk`=0, `frame_start`=0, and `fsync` at the inactive level given by `cfg_fs_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_rst_n | input | 1 | 0 holds the bit-clock generator idle |
| fsync_rst_n | input | 1 | 0 holds the frame sync logic idle |
| clk_sel | input | 1 | Bit-clock source: 0 internal divider, 1 external pin |
| ext_bclk | input | 1 | External bit clock, asynchronous |
| cfg_div | input | DIV_W | Half-period of the internal bit clock minus one |
| cfg_period | input | CNT_W | Bit clocks per frame minus one |
| cfg_width | input | CNT_W | Active frame sync bit clocks minus one |
| cfg_fs_low | input | 1 | 1: frame sync active low |
| cfg_free_run | input | 1 | 1: continuous frames, 0: one frame per trigger |
| frame_trig | input | 1 | Frame request used when not free-running |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| frame_start | output | 1 | One-cycle strobe at the first bit clock of a frame |

## Verification
Embedded properties check on every cycle that `frame_start` is a single-cycle strobe and that it follows a bit-clock rising edge. They also check that both hold controls force the bit clock, the frame sync and the strobe to their idle values, and that the bit counter never runs past the captured period. Exact frame lengths, pulse widths and bit-clock duty depend on counts over many cycles, so only the bench scenarios show them. The same applies to trigger-driven single frames, the synchronized external clock path, and the rule that configuration is deferred to the frame boundary. For these the bench sweeps divide, period and width values and compares the measured cycle counts against the arithmetic formulas.

// File: rtl/fsg_pkg.sv
// Shared constants and types for the frame sync generator.
// Assumes nothing beyond IEEE 1800-2017.
package fsg_pkg;

    // Bit-clock source encoding carried on the clk_sel port.
    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } clk_src_e;

    // Typical programming for a 16-bit stereo frame.
    localparam int unsigned STEREO16_PERIOD = 31;
    localparam int unsigned STEREO16_WIDTH  = 15;

endpackage

// File: rtl/fsg_divider.sv
// Internal bit-clock divider.
// Toggles bclk_o every div+1 cycles while run is high and flags, one cycle
// ahead, each rising transition. Assumes div may change only while the
// register output is low or at a rising flag (the framer guarantees this).
module fsg_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             bclk_o,
    output logic             rise_o
);

    logic [DIV_W-1:0] cnt_q;
    logic             bclk_q;
    logic             wrap;

    assign wrap   = (cnt_q >= div);
    assign rise_o = run && wrap && !bclk_q;
    assign bclk_o = bclk_q;

    // Half-period counter and bit-clock toggle register.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q  <= '0;
            bclk_q <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            bclk_q <= ~bclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assert_gen_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !bclk_q);

endmodule

// File: rtl/fsg_extsync.sv
// External bit-clock synchronizer.
// Brings an asynchronous pin into the clk domain through two flops and
// detects rising edges. Assumes the external clock is high and low for at
// least two system clocks each.
module fsg_extsync (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ext_in,
    output logic bclk_o,
    output logic rise_o
);

    logic s1_q, s2_q, s3_q;

    // Two-stage synchronizer for the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= ext_in;
            s2_q <= s1_q;
        end
    end

    // Gated delay stage: forms the output clock and the edge reference.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) s3_q <= 1'b0;
        else                s3_q <= s2_q;
    end

    assign rise_o = run && s2_q && !s3_q;
    assign bclk_o = s3_q;

    assert_ext_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !s3_q);

endmodule

// File: rtl/fsg_framer.sv
// Frame sync sequencer.
// Counts bit-clock rising ticks, starts frames (free-running or on request),
// drives the active frame sync level and a start strobe. All configuration
// is captured at a frame boundary; while held, the captured copy follows the
// inputs. Assumes ticks are at least two cycles apart.
module fsg_framer #(
    parameter int CNT_W = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs_rst_n,
    input  logic             tick,
    input  logic             trig,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_width,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_low,
    input  logic             cfg_free,
    output logic [DIV_W-1:0] div_q,
    output logic             fs_act_q,
    output logic             inv_q,
    output logic             start_q
);

    logic [CNT_W-1:0] bit_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] wid_q;
    logic [CNT_W-1:0] bit_nxt;
    logic             active_q;
    logic             pend_q;
    logic             boundary;
    logic             go;

    assign bit_nxt  = bit_q + 1'b1;
    assign boundary = !active_q || (bit_q >= per_q);
    assign go       = cfg_free || pend_q || trig;

    // Frame sequencing, configuration capture and trigger bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || !fs_rst_n) begin
            active_q <= 1'b0;
            bit_q    <= '0;
            fs_act_q <= 1'b0;
            start_q  <= 1'b0;
            pend_q   <= 1'b0;
            per_q    <= cfg_period;
            wid_q    <= cfg_width;
            div_q    <= cfg_div;
            inv_q    <= cfg_low;
        end else begin
            start_q <= 1'b0;
            if (trig) pend_q <= 1'b1;
            if (tick) begin
                if (boundary) begin
                    per_q <= cfg_period;
                    wid_q <= cfg_width;
                    div_q <= cfg_div;
                    inv_q <= cfg_low;
                    if (go) begin
                        active_q <= 1'b1;
                        bit_q    <= '0;
                        fs_act_q <= 1'b1;
                        start_q  <= 1'b1;
                        pend_q   <= 1'b0;
                    end else begin
                        active_q <= 1'b0;
                        fs_act_q <= 1'b0;
                    end
                end else begin
                    bit_q    <= bit_nxt;
                    fs_act_q <= (bit_nxt <= wid_q);
                end
            end
        end
    end

    assert_strobe_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);
    assert_strobe_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> $past(tick));
    assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (bit_q <= per_q));
    assert_fs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fs_rst_n) |-> (!start_q && !fs_act_q));

endmodule

// File: rtl/frame_sync_gen.sv
// Serial frame sync generator top.
// Selects the bit-clock source, feeds its rising ticks to the framer and
// applies the frame sync polarity. Assumes ext_bclk is slow enough to be
// sampled (each level held two or more system clocks).
module frame_sync_gen
    import fsg_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_rst_n,
    input  logic             fsync_rst_n,
    input  logic             clk_sel,
    input  logic             ext_bclk,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_width,
    input  logic             cfg_fs_low,
    input  logic             cfg_free_run,
    input  logic             frame_trig,
    output logic             bclk,
    output logic             fsync,
    output logic             frame_start
);

    clk_src_e         src;
    logic             run_int, run_ext;
    logic             bclk_int, bclk_ext;
    logic             rise_int, rise_ext;
    logic [DIV_W-1:0] div_q;
    logic             fs_act, inv_q;

    assign src     = clk_src_e'(clk_sel);
    assign run_int = gen_rst_n && (src == SRC_INTERNAL);
    assign run_ext = gen_rst_n && (src == SRC_EXTERNAL);

    fsg_divider #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_int),
        .div    (div_q),
        .bclk_o (bclk_int),
        .rise_o (rise_int)
    );

    fsg_extsync u_ext (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_ext),
        .ext_in (ext_bclk),
        .bclk_o (bclk_ext),
        .rise_o (rise_ext)
    );

    fsg_framer #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_frm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fs_rst_n   (fsync_rst_n),
        .tick       (rise_int | rise_ext),
        .trig       (frame_trig),
        .cfg_period (cfg_period),
        .cfg_width  (cfg_width),
        .cfg_div    (cfg_div),
        .cfg_low    (cfg_fs_low),
        .cfg_free   (cfg_free_run),
        .div_q      (div_q),
        .fs_act_q   (fs_act),
        .inv_q      (inv_q),
        .start_q    (frame_start)
    );

    // Both sources idle low when unselected, so an OR acts as the mux.
    assign bclk  = bclk_int | bclk_ext;
    assign fsync = fs_act ^ inv_q;

    assert_gen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(gen_rst_n) |-> !bclk);
    assert_fs_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fsync_rst_n) |-> (fsync == $past(cfg_fs_low)));

endmodule

// File: tb/frame_sync_gen_test.sv
module frame_sync_gen_test;

    localparam int DIV_W = 8;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             gen_rst_n = 1'b0;
    logic             fsync_rst_n = 1'b0;
    logic             clk_sel = 1'b0;
    logic             ext_bclk = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic [CNT_W-1:0] cfg_period = 8'd3;
    logic [CNT_W-1:0] cfg_width = 8'd1;
    logic             cfg_fs_low = 1'b0;
    logic             cfg_free_run = 1'b1;
    logic             frame_trig = 1'b0;
    logic             bclk, fsync, frame_start;

    int total = 0;
    int bad = 0;
    bit ext_on = 1'b0;
    int ext_ph = 0;
    localparam int EXT_H = 3;

    always #2 clk = ~clk;

    frame_sync_gen #(.DIV_W(DIV_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .gen_rst_n(gen_rst_n), .fsync_rst_n(fsync_rst_n),
        .clk_sel(clk_sel), .ext_bclk(ext_bclk), .cfg_div(cfg_div),
        .cfg_period(cfg_period), .cfg_width(cfg_width), .cfg_fs_low(cfg_fs_low),
        .cfg_free_run(cfg_free_run), .frame_trig(frame_trig),
        .bclk(bclk), .fsync(fsync), .frame_start(frame_start)
    );

    // External clock stimulus: toggles every EXT_H system clocks when enabled.
    always @(negedge clk) begin
        if (ext_on) begin
            ext_ph = ext_ph + 1;
            if (ext_ph == EXT_H) begin
                ext_ph = 0;
                ext_bclk = ~ext_bclk;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic restart();
        @(negedge clk);
        gen_rst_n = 1'b0;
        fsync_rst_n = 1'b0;
        @(negedge clk);
        gen_rst_n = 1'b1;
        fsync_rst_n = 1'b1;
    endtask

    task automatic wait_start(output bit got, input int lim);
        got = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (frame_start) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    // Called on a sample showing frame_start; stops on the next one.
    task automatic measure(output int per_c, output int act_c, output int hi_c);
        per_c = 1;
        act_c = (fsync != cfg_fs_low) ? 1 : 0;
        hi_c  = bclk ? 1 : 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (frame_start) break;
            per_c++;
            if (fsync != cfg_fs_low) act_c++;
            if (bclk) hi_c++;
        end
    endtask

    task automatic count_starts(input int cycles, output int n, output int hi);
        n = 0;
        hi = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (frame_start) n++;
            if (bclk) hi++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit got;
        int p_c, a_c, h_c, n, hi, mn;

        // R12: reset state
        cfg_fs_low = 1'b1;
        gen_rst_n = 1'b1;
        fsync_rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(bclk == 1'b0, "R12 bclk", bclk, 0);
        check(frame_start == 1'b0, "R12 frame_start", frame_start, 0);
        check(fsync == 1'b1, "R12 fsync", fsync, 1);
        cfg_fs_low = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R3 R4: sweep divide, period and width
        for (int d = 0; d <= 2; d++) begin
            for (int p = 1; p <= 5; p++) begin
                for (int w = 0; w <= p + 1; w++) begin
                    cfg_div = DIV_W'(d);
                    cfg_period = CNT_W'(p);
                    cfg_width = CNT_W'(w);
                    restart();
                    wait_start(got, 200);
                    check(got, "R4 frame seen", got, 1);
                    measure(p_c, a_c, h_c);
                    mn = (w < p) ? w : p;
                    check(p_c == (p + 1) * 2 * (d + 1), "R1 period", p_c, (p + 1) * 2 * (d + 1));
                    check(a_c == (mn + 1) * 2 * (d + 1), "R2 width", a_c, (mn + 1) * 2 * (d + 1));
                    check(h_c == (p + 1) * (d + 1), "R3 duty", h_c, (p + 1) * (d + 1));
                end
            end
        end

        // R1 R2: 16-bit stereo programming, back-to-back frames (R4)
        cfg_div = '0;
        cfg_period = CNT_W'(fsg_pkg::STEREO16_PERIOD);
        cfg_width = CNT_W'(fsg_pkg::STEREO16_WIDTH);
        restart();
        wait_start(got, 200);
        for (int k = 0; k < 3; k++) begin
            measure(p_c, a_c, h_c);
            check(p_c == 64, "R4 R1 stereo period", p_c, 64);
            check(a_c == 32, "R2 stereo width", a_c, 32);
        end

        // R10: strobe coincides with frame sync going active and lasts one cycle
        cfg_period = 8'd3;
        cfg_width = 8'd1;
        restart();
        wait_start(got, 200);
        check(fsync == 1'b1, "R10 fsync at start", fsync, 1);
        @(negedge clk);
        check(frame_start == 1'b0, "R10 one cycle", frame_start, 0);

        // R8: active-low frame sync
        cfg_fs_low = 1'b1;
        cfg_div = 8'd1;
        restart();
        wait_start(got, 200);
        check(fsync == 1'b0, "R8 active low at start", fsync, 0);
        measure(p_c, a_c, h_c);
        check(a_c == 8, "R8 low width", a_c, 8);
        check(p_c == 16, "R8 period", p_c, 16);

        // R7: frame logic held while generator runs
        @(negedge clk);
        fsync_rst_n = 1'b0;
        @(negedge clk);
        n = 0;
        hi = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (frame_start) n++;
            if (fsync != 1'b1) hi++;
        end
        check(n == 0, "R7 no strobe", n, 0);
        check(hi == 0, "R7 fsync inactive", hi, 0);
        count_starts(20, n, hi);
        check(hi > 0, "R7 bclk runs", hi, 1);
        cfg_fs_low = 1'b0;

        // R6: generator held
        @(negedge clk);
        fsync_rst_n = 1'b1;
        gen_rst_n = 1'b0;
        @(negedge clk);
        count_starts(80, n, hi);
        check(hi == 0, "R6 bclk low", hi, 0);
        check(n == 0, "R6 no frame", n, 0);

        // R5: one frame per trigger
        cfg_div = '0;
        cfg_free_run = 1'b0;
        restart();
        count_starts(150, n, hi);
        check(n == 0, "R5 idle without trigger", n, 0);
        @(negedge clk);
        frame_trig = 1'b1;
        @(negedge clk);
        frame_trig = 1'b0;
        count_starts(100, n, hi);
        check(n == 1, "R5 single frame", n, 1);
        cfg_free_run = 1'b1;

        // R11: mid-frame change applies to next frame
        cfg_period = 8'd3;
        cfg_width = 8'd1;
        restart();
        wait_start(got, 200);
        @(negedge clk);
        cfg_period = 8'd5;
        cfg_width = 8'd4;
        measure(p_c, a_c, h_c);
        p_c++;
        if (fsync) a_c = a_c;
        check(p_c == 8, "R11 current frame period", p_c, 8);
        measure(p_c, a_c, h_c);
        check(p_c == 12, "R11 next frame period", p_c, 12);
        check(a_c == 10, "R11 next frame width", a_c, 10);

        // R9: external bit clock source
        cfg_period = 8'd3;
        cfg_width = 8'd0;
        clk_sel = 1'b1;
        ext_on = 1'b1;
        restart();
        wait_start(got, 300);
        check(got, "R9 frame seen", got, 1);
        measure(p_c, a_c, h_c);
        check(p_c == 4 * 2 * EXT_H, "R9 period", p_c, 4 * 2 * EXT_H);
        check(a_c == 2 * EXT_H, "R9 width", a_c, 2 * EXT_H);
        check(h_c == 4 * EXT_H, "R9 bclk high", h_c, 4 * EXT_H);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule